// File: doc/BRIEF.md
# Byte-Oriented I2C Master With Host Registers

This block is an I2C bus master that a host processor steers one byte at a time through six byte-wide registers. The host sets a divider and a filter sampling value, enables the block and raises the master bit to put a START on the bus. It then writes bytes to the data register, or reads that register to pull bytes in, and ends the transfer by dropping the master bit, which puts a STOP on the bus. While still master, the host can insert a repeated START by writing control with the restart bit set.

After every byte the block holds SCL low and raises a completion bit and a sticky flag. The status register also shows the acknowledge sampled from the bus, a bus-busy indication decoded from START and STOP seen on the pins, and a sticky arbitration-lost bit. For received bytes, the host chooses the level the master drives in the acknowledge slot. Both pins are open drain: each output, when set, pulls its line low, and the real line level comes back on a separate input.

Top module: `i2cm_top`

## Requirements
- R1: After reset the registers read: control (offset 0x08) 0x00, status (0x0C) 0x80, divider (0x04) 0x31, filter (0x14) 0x01, own address (0x00) 0x00.
- R2: The own-address register keeps written bits 7:1 and always reads bit 0 as 0.
- R3: A control write with enable (bit 7) and master (bit 5) set, while master is clear, makes SDA fall while SCL is high. After that the status busy bit (bit 5) reads 1.
- R4: When control bit 4 (transmit) is set, a write to the data register (0x10) sends the byte MSB first, one bit per SCL period, and SDA is valid at the rising SCL edge. Between bytes the master holds SCL low.
- R5: Status bit 7 reads 0 while a byte is in flight and 1 after its ninth SCL clock. Status bit 1 sets at the same moment and stays set until the host writes 0 to status.
- R6: Status bit 0 holds the SDA level sampled in the ninth slot of the last byte (1 means NACK).
- R7: When control bit 4 is clear, a read of the data register returns the last received byte and starts the next reception. In the ninth slot the master pulls SDA low when control bit 3 is clear and releases it when bit 3 is set.
- R8: A control write with bit 2 set while master gives a repeated START. SDA rises while SCL is low, then SCL rises, then SDA falls at least half an SCL period later while SCL is still high. No STOP appears on the bus.
- R9: Clearing bit 5 while master gives a STOP. SDA rises while SCL is high, at least half a period after SCL rose, and the busy bit then returns to 0.
- R10: The SCL period in clocks is B*(A+2*floor(3*C/B)), where B = 16<<div[4:2] and C is filter bits 5:0 (a value of 0 counts as 1). A is picked by the index {div[5],div[1:0]}: 0→18, 1→20, 2→24, 3→30, 4→10, 5→12, 6→14, 7→16.
- R11: If SDA reads low during an address or data bit where the master releases it, status bits 4 and 1 set and control bit 5 reads 0. Both lines are released, and no STOP is generated.
- R12: SDA changes while SCL is high only inside START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle; has side effects on the data register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that the enable bit is not cleared in the middle of a transfer. They also assume that the host issues a new byte only after the previous one has completed, so the direction flag that routes the received byte stays put. The stimulus meets both assumptions: every transfer is paced by polling the completion flag, and enable stays set from the first START to the end. The bench slave changes SDA only while SCL is low, except when it deliberately pulls SDA low to lose arbitration for the master. That pull also happens while SCL is low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int OFF_OWN  = 'h00;
    localparam int OFF_DIV  = 'h04;
    localparam int OFF_CTL  = 'h08;
    localparam int OFF_STS  = 'h0C;
    localparam int OFF_DAT  = 'h10;
    localparam int OFF_FLT  = 'h14;

    localparam int CTL_EN   = 7;
    localparam int CTL_MST  = 5;
    localparam int CTL_TX   = 4;
    localparam int CTL_NAK  = 3;
    localparam int CTL_RS   = 2;

    localparam logic [5:0] DIV_RESET = 6'h31;
    localparam logic [5:0] FLT_RESET = 6'h01;

    typedef enum logic [2:0] {OP_START, OP_RSTART, OP_STOP, OP_WRITE, OP_READ} i2cm_op_e;
    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_RSPRE, ST_STOP, ST_WAIT, ST_BIT} i2cm_st_e;
    typedef enum logic [1:0] {CND_NONE, CND_START, CND_RSTART, CND_STOP} i2cm_cond_e;
endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
    parameter int Q_W = 16
) (
    input  logic [5:0]     div_code,
    input  logic [5:0]     flt_val,
    output logic [Q_W-1:0] quarter
);
    logic [2:0] gsel;
    logic [2:0] aidx;
    logic [4:0] a_val;
    logic [5:0] c_eff;
    logic [8:0] three_c;
    logic [8:0] corr;
    logic [8:0] base;
    logic [3:0] sh;

    always_comb begin
        gsel = div_code[4:2];
        aidx = {div_code[5], div_code[1:0]};
        case (aidx)
            3'd0:    a_val = 5'd18;
            3'd1:    a_val = 5'd20;
            3'd2:    a_val = 5'd24;
            3'd3:    a_val = 5'd30;
            3'd4:    a_val = 5'd10;
            3'd5:    a_val = 5'd12;
            3'd6:    a_val = 5'd14;
            default: a_val = 5'd16;
        endcase
        c_eff   = (flt_val == 6'd0) ? 6'd1 : flt_val;
        three_c = 9'({c_eff, 1'b0}) + 9'(c_eff);
        sh      = {1'b0, gsel} + 4'd4;
        corr    = three_c >> sh;
        base    = 9'(a_val) + {corr[7:0], 1'b0};
        quarter = Q_W'(base) << ({1'b0, gsel} + 4'd2);
    end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } mon_t;

    mon_t mon_d, mon_q;
    logic saw_start, saw_stop;

    always_comb begin
        mon_d     = mon_q;
        saw_start = mon_q.scl && scl_in && mon_q.sda && !sda_in;
        saw_stop  = mon_q.scl && scl_in && !mon_q.sda && sda_in;
        mon_d.scl = scl_in;
        mon_d.sda = sda_in;
        if (saw_start)     mon_d.busy = 1'b1;
        else if (saw_stop) mon_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        else        mon_q <= mon_d;
    end

    assign busy = mon_q.busy;
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int Q_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           abort,
    input  logic [Q_W-1:0] quarter,
    input  logic           cmd_valid,
    input  i2cm_op_e       cmd_op,
    input  logic [7:0]     cmd_data,
    input  logic           cmd_nack,
    input  logic           sda_in,
    output logic           ready,
    output logic           done,
    output logic [7:0]     rx_byte,
    output logic           rx_nack,
    output logic           arb_lost,
    output logic           scl_low,
    output logic           sda_low
);
    localparam int NBITS = 9;

    typedef struct packed {
        i2cm_st_e         st;
        logic [1:0]       ph;
        logic [Q_W-1:0]   cnt;
        logic [3:0]       bitn;
        logic [NBITS-1:0] tx;
        logic [NBITS-1:0] rx;
        logic             wr;
        logic             scl_low;
        logic             sda_low;
        logic             done;
        logic             al;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        eng_d.al   = 1'b0;
        tick       = (eng_q.cnt == quarter - Q_W'(1));
        if (eng_q.st == ST_IDLE || eng_q.st == ST_WAIT) eng_d.cnt = '0;
        else eng_d.cnt = tick ? '0 : eng_q.cnt + Q_W'(1);
        if (tick) eng_d.ph = eng_q.ph + 2'd1;

        case (eng_q.st)
            ST_IDLE: begin
                eng_d.scl_low = 1'b0;
                eng_d.sda_low = 1'b0;
                eng_d.ph      = 2'd0;
                if (cmd_valid && cmd_op == OP_START) eng_d.st = ST_START;
            end
            ST_WAIT: begin
                eng_d.ph   = 2'd0;
                eng_d.bitn = 4'd0;
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_RSTART: eng_d.st = ST_RSPRE;
                        OP_STOP:   eng_d.st = ST_STOP;
                        OP_WRITE: begin
                            eng_d.st = ST_BIT;
                            eng_d.tx = {cmd_data, 1'b1};
                            eng_d.wr = 1'b1;
                        end
                        OP_READ: begin
                            eng_d.st = ST_BIT;
                            eng_d.tx = {8'hFF, cmd_nack};
                            eng_d.wr = 1'b0;
                        end
                        default: eng_d.st = ST_WAIT;
                    endcase
                end
            end
            ST_START: if (tick) begin
                if (eng_q.ph == 2'd1) eng_d.sda_low = 1'b1;
                if (eng_q.ph == 2'd3) begin
                    eng_d.st      = ST_WAIT;
                    eng_d.scl_low = 1'b1;
                end
            end
            ST_RSPRE: if (tick) begin
                if (eng_q.ph == 2'd0) eng_d.sda_low = 1'b0;
                if (eng_q.ph == 2'd1) eng_d.scl_low = 1'b0;
                if (eng_q.ph == 2'd3) eng_d.st = ST_START;
            end
            ST_STOP: if (tick) begin
                if (eng_q.ph == 2'd0) eng_d.sda_low = 1'b1;
                if (eng_q.ph == 2'd1) eng_d.scl_low = 1'b0;
                if (eng_q.ph == 2'd3) begin
                    eng_d.sda_low = 1'b0;
                    eng_d.st      = ST_IDLE;
                end
            end
            ST_BIT: if (tick) begin
                case (eng_q.ph)
                    2'd0: eng_d.sda_low = ~eng_q.tx[NBITS-1];
                    2'd1: eng_d.scl_low = 1'b0;
                    2'd2: begin
                        eng_d.rx = {eng_q.rx[NBITS-2:0], sda_in};
                        if (eng_q.wr && eng_q.bitn != 4'(NBITS-1) &&
                            eng_q.tx[NBITS-1] && !sda_in) begin
                            eng_d.st      = ST_IDLE;
                            eng_d.al      = 1'b1;
                            eng_d.scl_low = 1'b0;
                            eng_d.sda_low = 1'b0;
                        end
                    end
                    default: begin
                        eng_d.scl_low = 1'b1;
                        eng_d.tx      = {eng_q.tx[NBITS-2:0], 1'b1};
                        if (eng_q.bitn == 4'(NBITS-1)) begin
                            eng_d.st   = ST_WAIT;
                            eng_d.done = 1'b1;
                        end else begin
                            eng_d.bitn = eng_q.bitn + 4'd1;
                        end
                    end
                endcase
            end
            default: eng_d.st = ST_IDLE;
        endcase

        if (abort) begin
            eng_d.st      = ST_IDLE;
            eng_d.scl_low = 1'b0;
            eng_d.sda_low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign ready    = (eng_q.st == ST_IDLE) || (eng_q.st == ST_WAIT);
    assign done     = eng_q.done;
    assign rx_byte  = eng_q.rx[NBITS-1:1];
    assign rx_nack  = eng_q.rx[0];
    assign arb_lost = eng_q.al;
    assign scl_low  = eng_q.scl_low;
    assign sda_low  = eng_q.sda_low;

    AST_SDA_MOVES_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n || abort)
        (!$stable(eng_q.sda_low) && !eng_q.scl_low && !$past(eng_q.scl_low))
        |-> ($past(eng_q.st) == ST_START || $past(eng_q.st) == ST_STOP)); // R12
    AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |-> $past(eng_q.st) == ST_BIT); // R5
    AST_AL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.al |-> ($past(eng_q.wr) && !eng_q.scl_low && !eng_q.sda_low)); // R11
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n || abort)
        (eng_q.st == ST_WAIT) |-> eng_q.scl_low); // R4
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int Q_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int QMIN = 40;

    typedef struct packed {
        logic [6:0] own;
        logic [5:0] dv;
        logic [5:0] flt;
        logic       en;
        logic       msta;
        logic       mtx;
        logic       txak;
        logic       mcf;
        logic       mal;
        logic       mif;
        logic       rxak;
        logic [7:0] data;
        i2cm_cond_e cond;
        logic       bpend;
        logic       bwr;
    } regs_t;

    regs_t reg_d, reg_q;

    logic [Q_W-1:0] quarter;
    logic           busy;
    logic           eng_ready, eng_done, eng_rx_nack, eng_al;
    logic [7:0]     eng_rx;
    logic           cmd_valid;
    i2cm_op_e       cmd_op;
    logic           sts_write;

    i2cm_clkdiv #(.Q_W(Q_W)) u_div (
        .div_code (reg_q.dv),
        .flt_val  (reg_q.flt),
        .quarter  (quarter)
    );

    i2cm_busmon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (busy)
    );

    i2cm_engine #(.Q_W(Q_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!reg_q.en),
        .quarter   (quarter),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (reg_q.data),
        .cmd_nack  (reg_q.txak),
        .sda_in    (sda_in),
        .ready     (eng_ready),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .rx_nack   (eng_rx_nack),
        .arb_lost  (eng_al),
        .scl_low   (scl_oe),
        .sda_low   (sda_oe)
    );

    always_comb begin
        cmd_valid = eng_ready && reg_q.en && (reg_q.cond != CND_NONE || reg_q.bpend);
        case (reg_q.cond)
            CND_START:  cmd_op = OP_START;
            CND_RSTART: cmd_op = OP_RSTART;
            CND_STOP:   cmd_op = OP_STOP;
            default:    cmd_op = reg_q.bwr ? OP_WRITE : OP_READ;
        endcase
    end

    assign sts_write = reg_wr && (int'(reg_addr) == OFF_STS);

    always_comb begin
        reg_d = reg_q;
        if (cmd_valid) begin
            if (reg_q.cond != CND_NONE) begin
                reg_d.cond = CND_NONE;
            end else begin
                reg_d.bpend = 1'b0;
                reg_d.mcf   = 1'b0;
            end
        end

        if (reg_wr) begin
            case (int'(reg_addr))
                OFF_OWN: reg_d.own = reg_wdata[7:1];
                OFF_DIV: reg_d.dv  = reg_wdata[5:0];
                OFF_FLT: reg_d.flt = reg_wdata[5:0];
                OFF_STS: begin
                    reg_d.mal = reg_wdata[4];
                    reg_d.mif = reg_wdata[1];
                end
                OFF_CTL: begin
                    reg_d.en   = reg_wdata[CTL_EN];
                    reg_d.mtx  = reg_wdata[CTL_TX];
                    reg_d.txak = reg_wdata[CTL_NAK];
                    reg_d.msta = reg_wdata[CTL_MST] && reg_wdata[CTL_EN];
                    if (!reg_wdata[CTL_EN]) begin
                        reg_d.cond  = CND_NONE;
                        reg_d.bpend = 1'b0;
                    end else if (!reg_q.msta && reg_wdata[CTL_MST]) begin
                        reg_d.cond = CND_START;
                    end else if (reg_q.msta && reg_wdata[CTL_MST] && reg_wdata[CTL_RS]) begin
                        reg_d.cond = CND_RSTART;
                    end else if (reg_q.msta && !reg_wdata[CTL_MST]) begin
                        reg_d.cond = CND_STOP;
                    end
                end
                OFF_DAT: begin
                    reg_d.data = reg_wdata;
                    if (reg_q.en && reg_q.mtx) begin
                        reg_d.bpend = 1'b1;
                        reg_d.bwr   = 1'b1;
                    end
                end
                default: reg_d.data = reg_q.data;
            endcase
        end

        if (reg_rd && int'(reg_addr) == OFF_DAT && reg_q.en && !reg_q.mtx) begin
            reg_d.bpend = 1'b1;
            reg_d.bwr   = 1'b0;
        end

        if (eng_done) begin
            reg_d.mcf  = 1'b1;
            reg_d.mif  = 1'b1;
            reg_d.rxak = eng_rx_nack;
            if (!reg_q.bwr) reg_d.data = eng_rx;
        end
        if (eng_al) begin
            reg_d.mal   = 1'b1;
            reg_d.mif   = 1'b1;
            reg_d.mcf   = 1'b1;
            reg_d.msta  = 1'b0;
            reg_d.cond  = CND_NONE;
            reg_d.bpend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= '{cond: CND_NONE, default: '0};
            reg_q.dv   <= DIV_RESET;
            reg_q.flt  <= FLT_RESET;
            reg_q.mcf  <= 1'b1;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        case (int'(reg_addr))
            OFF_OWN: reg_rdata = {reg_q.own, 1'b0};
            OFF_DIV: reg_rdata = {2'b00, reg_q.dv};
            OFF_FLT: reg_rdata = {2'b00, reg_q.flt};
            OFF_CTL: reg_rdata = {reg_q.en, 1'b0, reg_q.msta, reg_q.mtx, reg_q.txak, 3'b000};
            OFF_STS: reg_rdata = {reg_q.mcf, 1'b0, busy, reg_q.mal, 2'b00, reg_q.mif, reg_q.rxak};
            OFF_DAT: reg_rdata = reg_q.data;
            default: reg_rdata = 8'h00;
        endcase
    end

    AST_AL_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_al && !reg_wr) |=> !reg_q.msta); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.mif && !sts_write) |=> reg_q.mif); // R5
    AST_QUARTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        quarter >= Q_W'(QMIN)); // R10
endmodule

// File: tb/i2cm_top_bench.sv
`timescale 1ns/1ps
module i2cm_top_bench;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              scl_oe, sda_oe;
    logic              slv_sda_low = 1'b0;
    wire               scl_line = !scl_oe;
    wire               sda_line = !sda_oe && !slv_sda_low;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    longint t_scl_rise = 0;
    longint t_start = 0;
    longint t_stop = 0;

    always #4 clk = ~clk;

    i2cm_top #(.ADDR_W(ADDR_W), .Q_W(16)) u_i2cm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always @(posedge scl_line) t_scl_rise = $time;
    always @(negedge sda_line) if (scl_line === 1'b1) begin start_cnt++; t_start = $time; end
    always @(posedge sda_line) if (scl_line === 1'b1) begin stop_cnt++;  t_stop  = $time; end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_rd = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int exp_period(input int dv, input int c);
        int a, b, cc;
        case ({dv[5], dv[1:0]})
            3'd0: a = 18; 3'd1: a = 20; 3'd2: a = 24; 3'd3: a = 30;
            3'd4: a = 10; 3'd5: a = 12; 3'd6: a = 14; default: a = 16;
        endcase
        cc = (c == 0) ? 1 : c;
        b  = 16 << dv[4:2];
        return b * (a + 2 * ((3 * cc) / b));
    endfunction

    function automatic int enc_div(input int idx, input int g);
        return ((idx >> 2) << 5) | (g << 2) | (idx & 3);
    endfunction

    task automatic wait_mif();
        int v;
        for (int i = 0; i < 20000; i++) begin
            rd('h0C, v);
            if (v[1]) break;
        end
    endtask

    task automatic wait_starts(input int n);
        for (int i = 0; i < 5000 && start_cnt < n; i++) @(posedge clk);
    endtask

    task automatic slave_rx(input bit ack, output int got, output int per);
        longint t1;
        got = 0; t1 = 0; per = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            if (i == 0) t1 = $time;
            if (i == 1) per = int'(($time - t1) / 8);
            got = ((got << 1) | int'(sda_line)) & 'hFF;
        end
        @(negedge scl_line);
        slv_sda_low = ack;
        @(posedge scl_line);
        @(negedge scl_line);
        slv_sda_low = 1'b0;
    endtask

    task automatic slave_tx(input int d, output int mack);
        for (int i = 7; i >= 0; i--) begin
            slv_sda_low = !d[i];
            @(posedge scl_line);
            @(negedge scl_line);
        end
        slv_sda_low = 1'b0;
        @(posedge scl_line);
        mack = int'(sda_line);
        @(negedge scl_line);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, got, per, mack, dv, c, d, s0, n0;
        int rxd[3];
        void'($urandom(32'd7321));
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        start_cnt = 0; stop_cnt = 0;

        rd('h08, v); chk("R1 ctrl", v, 'h00);
        rd('h0C, v); chk("R1 status", v, 'h80);
        rd('h04, v); chk("R1 divider", v, 'h31);
        rd('h14, v); chk("R1 filter", v, 'h01);
        rd('h00, v); chk("R1 own", v, 'h00);

        wr('h00, 'hA7); rd('h00, v); chk("R2 own bit0", v, 'hA6);

        wr('h04, 'h20); wr('h14, 1);
        wr('h08, 'hB0);
        wait_starts(1);
        repeat (4) @(posedge clk);
        chk("R3 start seen", start_cnt, 1);
        rd('h0C, v); chk("R3 busy", v & 'h20, 'h20);
        wait (!scl_line);

        wr('h10, 'hA0);
        repeat (3) @(posedge clk);
        rd('h0C, v); chk("R5 in flight", v & 'h80, 0);
        slave_rx(1'b1, got, per);
        chk("R4 byte", got, 'hA0);
        chk("R10 period", per, exp_period('h20, 1));
        wait_mif();
        rd('h0C, v); chk("R5 R6 done status", v, 'hA2);
        repeat (50) @(posedge clk);
        rd('h0C, v); chk("R5 flag sticky", v & 'h02, 'h02);
        wr('h0C, 0);
        rd('h0C, v); chk("R5 flag cleared", v, 'hA0);

        for (int k = 0; k < 6; k++) begin
            bit ack;
            dv = enc_div(int'($urandom % 8), (k == 0) ? 1 : 0);
            c  = (k == 1) ? 0 : int'($urandom % 7);
            d  = int'($urandom % 256);
            ack = 1'($urandom % 2);
            wr('h04, dv); wr('h14, c);
            wr('h10, d);
            slave_rx(ack, got, per);
            chk("R4 random byte", got, d);
            chk("R10 random period", per, exp_period(dv, c));
            wait_mif();
            rd('h0C, v); chk("R6 ack level", v & 1, ack ? 0 : 1);
            wr('h0C, 0);
        end

        wr('h04, 'h20); wr('h14, 1);
        s0 = stop_cnt; n0 = start_cnt;
        wr('h08, 'hB4);
        wait_starts(n0 + 1);
        chk("R8 restart seen", start_cnt, n0 + 1);
        chk("R8 no stop", stop_cnt, s0);
        chk("R8 hold", (t_start - t_scl_rise) >= 80 * 8, 1);
        wait (!scl_line);
        wr('h10, 'hA1);
        slave_rx(1'b1, got, per);
        chk("R8 addr after restart", got, 'hA1);
        wait_mif(); wr('h0C, 0);

        wr('h08, 'hA0);
        rd('h10, v);
        for (int k = 0; k < 3; k++) begin
            rxd[k] = int'($urandom % 256);
            slave_tx(rxd[k], mack);
            wait_mif(); wr('h0C, 0);
            chk("R7 ack slot", mack, (k == 2) ? 1 : 0);
            if (k == 1) wr('h08, 'hA8);
            if (k == 2) wr('h08, 'hB8);
            rd('h10, v);
            chk("R7 rx byte", v, rxd[k]);
        end

        s0 = stop_cnt;
        wr('h08, 'h80);
        for (int i = 0; i < 5000 && stop_cnt == s0; i++) @(posedge clk);
        chk("R9 stop seen", stop_cnt, s0 + 1);
        chk("R9 setup", (t_stop - t_scl_rise) >= 80 * 8, 1);
        repeat (5) @(posedge clk);
        rd('h0C, v); chk("R9 busy cleared", v & 'h20, 0);

        n0 = start_cnt;
        wr('h08, 'hB0);
        wait_starts(n0 + 1);
        wait (!scl_line);
        s0 = stop_cnt;
        wr('h10, 'hC5);
        slv_sda_low = 1'b1;
        wait_mif();
        rd('h0C, v); chk("R11 status bits", v & 'h32, 'h32);
        rd('h08, v); chk("R11 master dropped", v, 'h90);
        repeat (5) @(posedge clk);
        chk("R11 lines released", {28'd0, scl_line, sda_oe}, 2);
        chk("R11 no stop", stop_cnt, s0);
        slv_sda_low = 1'b0;
        repeat (5) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule